// File: doc/BRIEF.md
# Four-Slot Transmit Descriptor Unit

This block runs the transmit side of a small Ethernet controller that keeps four fixed descriptor slots instead of a descriptor ring in memory. Every slot has a buffer base-address register and a status/command word. Software writes a byte count into a slot's status word, and that write hands the slot to the hardware. Slots are served one at a time, in fixed rotation. For the active slot the block fetches the frame one byte at a time over a request/acknowledge memory port. It signals the MAC to start sending once enough bytes sit in the transmit FIFO. It then records the outcome reported by the MAC in the slot's status bits.

Two flags track completion. The "fetched" flag rises when the last byte has been moved. The "sent" flag rises when the MAC reports a good end of frame. There are also four error flags: FIFO underrun, late collision, abort and carrier lost. A collision counter aborts a frame on its own once a configured retry budget is used up. A shared interrupt-status word gains a "sent" bit or an "error" bit at the end of every frame. It also holds a sticky bit that records a status write to a slot that was still busy. Each of these bits is cleared by writing one to it.

Top module: `txdesc_unit`

## Requirements
- R1: After reset every slot status word and every base-address register reads 0, the interrupt-status word reads 0, `slot_free` is all ones, and `mem_req` and `tx_start` are low.
- R2: A status write to an idle slot stores the byte count from bits 12:0 and the start threshold from bits 21:16. It clears bits 13, 14, 15, 29, 30 and 31. The slot is queued only if the byte count is non-zero. A zero count leaves the slot idle, and no fetch begins.
- R3: Queued slots are served strictly in the order 0, 1, 2, 3, 0, and so on. A slot queued out of turn waits, with no memory request, until every slot ahead of it has ended.
- R4: While a slot is active, `mem_req` stays high until the byte count has been fetched. `mem_addr` equals the slot base plus the number of bytes already accepted. Each cycle with `mem_req` and `mem_ack` both high moves one byte. Status bit 13 (fetched) rises after the last byte is accepted.
- R5: `tx_start` is a one-cycle pulse, given once per frame, in the cycle after the accepted-byte count first reaches the start point. The start point is threshold×32, capped at the byte count. A threshold of 0 means the start point is the full byte count.
- R6: A `mac_done` after the last byte has been fetched ends the frame. It sets status bit 15 (sent) and interrupt bit 2.
- R7: A `mac_done` before the last byte has been fetched ends the frame as an underrun. It sets status bit 14 and interrupt bit 3, leaves bit 13 clear, and stops the fetch.
- R8: `mac_abort` during sending ends the frame. It sets status bit 30 and interrupt bit 3. It takes priority over a `mac_done` in the same cycle.
- R9: The retry field sits in bits 7:4 of the configuration word at offset 0x24. When the count of `mac_coll` pulses in one frame reaches 16 + 16×retry field, the frame ends with status bit 30 and interrupt bit 3, without any `mac_abort`.
- R10: `mac_late_coll` during sending sets status bit 29, and `mac_no_carrier` sets status bit 31. Neither one ends the frame.
- R11: Offset 0x20 is the interrupt-status word. Writing to it clears exactly the bits written as one and leaves the others unchanged.
- R12: A status write to a queued or active slot leaves that slot unchanged and sets sticky interrupt bit 15.
- R13: `slot_free[i]` is high when slot i's byte count is zero, or when both its bit 13 and bit 15 are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write: status words at 0x00–0x0C, base addresses at 0x10–0x1C, interrupt status at 0x20, configuration at 0x24 |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the combinational read |
| rd_data | output | 32 | Read data |
| slot_free | output | 4 | Per-slot free indication |
| mem_req | output | 1 | Byte fetch request |
| mem_addr | output | 32 | Byte address of the fetch |
| mem_ack | input | 1 | Fetch accepted this cycle |
| tx_start | output | 1 | One-cycle pulse telling the MAC to begin sending |
| mac_done | input | 1 | MAC reports end of frame |
| mac_abort | input | 1 | MAC reports the frame was abandoned |
| mac_coll | input | 1 | One collision seen during this cycle |
| mac_late_coll | input | 1 | Collision outside the allowed window |
| mac_no_carrier | input | 1 | Carrier lost during sending |

## Verification
A wrong rotation pointer or a wrong per-slot state shows up on `mem_addr` at the very first byte request of the next frame, because every request is checked against the base of the slot the rotation predicts. A wrong byte counter shows up either in the cycle when `tx_start` fires or in the total number of accepted bytes. A wrong end-of-frame decision shows up in the status word and the interrupt word one cycle after the MAC input pulse. Sweeps over sizes and thresholds, both above and below the size, together with the collision limit, underrun, abort, busy-write and zero-size cases, expose each of these within a few cycles.

// File: rtl/txd_pkg.sv
package txd_pkg;

  localparam int SIZE_W    = 13;
  localparam int THR_LSB   = 16;
  localparam int THR_W     = 6;
  localparam int ST_OWN    = 13;
  localparam int ST_TUN    = 14;
  localparam int ST_TOK    = 15;
  localparam int ST_OWC    = 29;
  localparam int ST_TABT   = 30;
  localparam int ST_CRS    = 31;
  localparam int ISR_W     = 16;
  localparam int ISR_TOK   = 2;
  localparam int ISR_TER   = 3;
  localparam int ISR_BUSY  = 15;
  localparam int RETRY_LSB = 4;
  localparam int RETRY_W   = 4;
  localparam int COLL_W    = RETRY_W + 5;

  typedef enum logic [2:0] {
    SL_IDLE, SL_QUEUED, SL_FETCH, SL_SEND, SL_OK, SL_FAIL
  } slot_state_e;

  typedef enum logic [1:0] {
    END_NONE, END_OK, END_UNDER, END_ABORT
  } end_kind_e;

endpackage

// File: rtl/txd_slot.sv
module txd_slot
  import txd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stat_we,
  input  logic        addr_we,
  input  logic [31:0] wdata,
  input  logic        sel,
  input  logic        ev_begin,
  input  logic        ev_send,
  input  logic        ev_own,
  input  logic        ev_owc,
  input  logic        ev_crs,
  input  end_kind_e   ev_end,
  output logic [31:0] stat_word,
  output logic [31:0] base_addr,
  output logic        queued,
  output logic        busy,
  output logic        free
);

  slot_state_e        state_q, state_d;
  logic [SIZE_W-1:0]  size_q, size_d;
  logic [THR_W-1:0]   thr_q, thr_d;
  logic               own_q, own_d, tun_q, tun_d, tok_q, tok_d;
  logic               owc_q, owc_d, tabt_q, tabt_d, crs_q, crs_d;
  logic [31:0]        base_q;
  logic               take_wr;

  assign busy    = (state_q == SL_QUEUED) || (state_q == SL_FETCH) || (state_q == SL_SEND);
  assign queued  = (state_q == SL_QUEUED);
  assign take_wr = stat_we && !busy;

  always_comb begin
    state_d = state_q;
    size_d  = size_q;
    thr_d   = thr_q;
    own_d   = own_q;
    tun_d   = tun_q;
    tok_d   = tok_q;
    owc_d   = owc_q;
    tabt_d  = tabt_q;
    crs_d   = crs_q;
    if (take_wr) begin
      size_d  = wdata[SIZE_W-1:0];
      thr_d   = wdata[THR_LSB +: THR_W];
      own_d   = 1'b0;
      tun_d   = 1'b0;
      tok_d   = 1'b0;
      owc_d   = 1'b0;
      tabt_d  = 1'b0;
      crs_d   = 1'b0;
      state_d = (wdata[SIZE_W-1:0] != '0) ? SL_QUEUED : SL_IDLE;
    end else if (sel) begin
      if (ev_begin) state_d = SL_FETCH;
      if (ev_send)  state_d = SL_SEND;
      if (ev_own)   own_d   = 1'b1;
      if (ev_owc)   owc_d   = 1'b1;
      if (ev_crs)   crs_d   = 1'b1;
      case (ev_end)
        END_OK:    begin tok_d  = 1'b1; state_d = SL_OK;   end
        END_UNDER: begin tun_d  = 1'b1; state_d = SL_FAIL; end
        END_ABORT: begin tabt_d = 1'b1; state_d = SL_FAIL; end
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SL_IDLE;
      size_q  <= '0;
      thr_q   <= '0;
      own_q   <= 1'b0;
      tun_q   <= 1'b0;
      tok_q   <= 1'b0;
      owc_q   <= 1'b0;
      tabt_q  <= 1'b0;
      crs_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      size_q  <= size_d;
      thr_q   <= thr_d;
      own_q   <= own_d;
      tun_q   <= tun_d;
      tok_q   <= tok_d;
      owc_q   <= owc_d;
      tabt_q  <= tabt_d;
      crs_q   <= crs_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (addr_we) begin
      base_q <= wdata;
    end
  end

  assign stat_word = {crs_q, tabt_q, owc_q, 7'd0, thr_q, tok_q, tun_q, own_q, size_q};
  assign base_addr = base_q;
  assign free      = (size_q == '0) || (own_q && tok_q);

  AST_TOK_NEEDS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    tok_q |-> own_q); // R6
  AST_BUSY_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && busy) |=> (size_q == $past(size_q))); // R12

endmodule

// File: rtl/txd_engine.sv
module txd_engine
  import txd_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int PTR_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] slot_queued,
  input  logic [SIZE_W-1:0]    act_size,
  input  logic [THR_W-1:0]     act_thr,
  input  logic [31:0]          act_base,
  input  logic [RETRY_W-1:0]   retry_cfg,
  input  logic                 mem_ack,
  input  logic                 mac_done,
  input  logic                 mac_abort,
  input  logic                 mac_coll,
  input  logic                 mac_late_coll,
  input  logic                 mac_no_carrier,
  output logic [PTR_W-1:0]     ptr,
  output logic                 ev_begin,
  output logic                 ev_send,
  output logic                 ev_own,
  output logic                 ev_owc,
  output logic                 ev_crs,
  output end_kind_e            ev_end,
  output logic                 mem_req,
  output logic [31:0]          mem_addr,
  output logic                 tx_start
);

  typedef enum logic {E_IDLE, E_RUN} eng_state_e;

  eng_state_e         st_q, st_d;
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic [SIZE_W-1:0]  cnt_q, cnt_d, cnt_nxt, start_pt, thr_bytes;
  logic [COLL_W-1:0]  coll_q, coll_d, limit;
  logic               wire_q, wire_d;
  logic               run, take, full_nxt, sending;

  assign run       = (st_q == E_RUN);
  assign limit     = {1'b0, retry_cfg, 4'd0} + COLL_W'(16);
  assign thr_bytes = SIZE_W'({act_thr, 5'd0});
  assign start_pt  = (act_thr == '0) ? act_size :
                     ((thr_bytes < act_size) ? thr_bytes : act_size);
  assign mem_req   = run && (cnt_q != act_size);
  assign take      = mem_req && mem_ack;
  assign cnt_nxt   = cnt_q + SIZE_W'(take);
  assign full_nxt  = (cnt_nxt == act_size);
  assign sending   = run && wire_q;
  assign mem_addr  = act_base + 32'(cnt_q);
  assign tx_start  = run && !wire_q && (cnt_q >= start_pt);

  assign ev_begin  = (st_q == E_IDLE) && slot_queued[ptr_q];
  assign ev_send   = tx_start;
  assign ev_own    = take && full_nxt;
  assign ev_owc    = sending && mac_late_coll;
  assign ev_crs    = sending && mac_no_carrier;
  assign ptr       = ptr_q;

  always_comb begin
    ev_end = END_NONE;
    if (sending) begin
      if (mac_abort)                                  ev_end = END_ABORT;
      else if (mac_done)                              ev_end = full_nxt ? END_OK : END_UNDER;
      else if (mac_coll && (coll_q + 1'b1 == limit))  ev_end = END_ABORT;
    end
  end

  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    cnt_d  = cnt_q;
    coll_d = coll_q;
    wire_d = wire_q;
    if (st_q == E_IDLE) begin
      if (ev_begin) begin
        st_d   = E_RUN;
        cnt_d  = '0;
        coll_d = '0;
        wire_d = 1'b0;
      end
    end else begin
      cnt_d = cnt_nxt;
      if (tx_start)             wire_d = 1'b1;
      if (sending && mac_coll)  coll_d = coll_q + 1'b1;
      if (ev_end != END_NONE) begin
        st_d  = E_IDLE;
        ptr_d = (32'(ptr_q) == NUM_SLOTS - 1) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      ptr_q  <= '0;
      cnt_q  <= '0;
      coll_q <= '0;
      wire_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      cnt_q  <= cnt_d;
      coll_q <= coll_d;
      wire_q <= wire_d;
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_end != END_NONE) |=> (32'(ptr_q) == (32'($past(ptr_q)) + 1) % NUM_SLOTS)); // R3
  AST_START_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start); // R5
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_end != END_NONE) |=> !mem_req); // R7

endmodule

// File: rtl/txd_irq.sv
module txd_irq
  import txd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_tok,
  input  logic             set_ter,
  input  logic             set_busy,
  input  logic             clr_we,
  input  logic [ISR_W-1:0] clr_mask,
  output logic [ISR_W-1:0] isr
);

  logic [ISR_W-1:0] isr_q, isr_d, set_v;
  logic             upd_en;

  always_comb begin
    set_v           = '0;
    set_v[ISR_TOK]  = set_tok;
    set_v[ISR_TER]  = set_ter;
    set_v[ISR_BUSY] = set_busy;
    isr_d           = (clr_we ? (isr_q & ~clr_mask) : isr_q) | set_v;
    upd_en          = clr_we || (set_v != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
    end else if (upd_en) begin
      isr_q <= isr_d;
    end
  end

  assign isr = isr_q;

  AST_TOK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    set_tok |=> isr_q[ISR_TOK]); // R6
  AST_TER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    set_ter |=> isr_q[ISR_TER]); // R7
  AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    set_busy |=> isr_q[ISR_BUSY]); // R12

endmodule

// File: rtl/txdesc_unit.sv
module txdesc_unit
  import txd_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [31:0]          wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [31:0]          rd_data,
  output logic [NUM_SLOTS-1:0] slot_free,
  output logic                 mem_req,
  output logic [31:0]          mem_addr,
  input  logic                 mem_ack,
  output logic                 tx_start,
  input  logic                 mac_done,
  input  logic                 mac_abort,
  input  logic                 mac_coll,
  input  logic                 mac_late_coll,
  input  logic                 mac_no_carrier
);

  localparam int PTR_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int WIDX_W  = ADDR_W - 2;
  localparam int IDX_ISR = 2 * NUM_SLOTS;
  localparam int IDX_CFG = 2 * NUM_SLOTS + 1;

  logic [WIDX_W-1:0]    wr_w, rd_w;
  logic                 wr_ok, rd_ok;
  logic [31:0]          stat_arr [NUM_SLOTS];
  logic [31:0]          base_arr [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] queued_v, busy_v, stat_we_v;
  logic [PTR_W-1:0]     ptr;
  logic                 ev_begin, ev_send, ev_own, ev_owc, ev_crs;
  end_kind_e            ev_end;
  logic [RETRY_W-1:0]   retry_q;
  logic                 cfg_we, isr_we;
  logic [ISR_W-1:0]     isr;

  assign wr_w   = wr_addr[ADDR_W-1:2];
  assign rd_w   = rd_addr[ADDR_W-1:2];
  assign wr_ok  = wr_en && (wr_addr[1:0] == 2'b00);
  assign rd_ok  = (rd_addr[1:0] == 2'b00);
  assign cfg_we = wr_ok && (wr_w == WIDX_W'(IDX_CFG));
  assign isr_we = wr_ok && (wr_w == WIDX_W'(IDX_ISR));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign stat_we_v[i] = wr_ok && (wr_w == WIDX_W'(i));
    txd_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .stat_we   (stat_we_v[i]),
      .addr_we   (wr_ok && (wr_w == WIDX_W'(NUM_SLOTS + i))),
      .wdata     (wr_data),
      .sel       (ptr == PTR_W'(i)),
      .ev_begin  (ev_begin),
      .ev_send   (ev_send),
      .ev_own    (ev_own),
      .ev_owc    (ev_owc),
      .ev_crs    (ev_crs),
      .ev_end    (ev_end),
      .stat_word (stat_arr[i]),
      .base_addr (base_arr[i]),
      .queued    (queued_v[i]),
      .busy      (busy_v[i]),
      .free      (slot_free[i])
    );
  end

  txd_engine #(.NUM_SLOTS(NUM_SLOTS)) u_engine (
    .clk            (clk),
    .rst_n          (rst_n),
    .slot_queued    (queued_v),
    .act_size       (stat_arr[ptr][SIZE_W-1:0]),
    .act_thr        (stat_arr[ptr][THR_LSB +: THR_W]),
    .act_base       (base_arr[ptr]),
    .retry_cfg      (retry_q),
    .mem_ack        (mem_ack),
    .mac_done       (mac_done),
    .mac_abort      (mac_abort),
    .mac_coll       (mac_coll),
    .mac_late_coll  (mac_late_coll),
    .mac_no_carrier (mac_no_carrier),
    .ptr            (ptr),
    .ev_begin       (ev_begin),
    .ev_send        (ev_send),
    .ev_own         (ev_own),
    .ev_owc         (ev_owc),
    .ev_crs         (ev_crs),
    .ev_end         (ev_end),
    .mem_req        (mem_req),
    .mem_addr       (mem_addr),
    .tx_start       (tx_start)
  );

  txd_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_tok  (ev_end == END_OK),
    .set_ter  ((ev_end == END_UNDER) || (ev_end == END_ABORT)),
    .set_busy (|(stat_we_v & busy_v)),
    .clr_we   (isr_we),
    .clr_mask (wr_data[ISR_W-1:0]),
    .isr      (isr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retry_q <= '0;
    end else if (cfg_we) begin
      retry_q <= wr_data[RETRY_LSB +: RETRY_W];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_ok) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (rd_w == WIDX_W'(i))             rd_data = stat_arr[i];
        if (rd_w == WIDX_W'(NUM_SLOTS + i)) rd_data = base_arr[i];
      end
      if (rd_w == WIDX_W'(IDX_ISR)) rd_data = 32'(isr);
      if (rd_w == WIDX_W'(IDX_CFG)) rd_data = 32'(retry_q) << RETRY_LSB;
    end
  end

  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy_v & ~queued_v)); // R3

endmodule

// File: tb/tb_txdesc_unit.sv
module tb_txdesc_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data;
  logic [3:0]  slot_free;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack;
  logic        tx_start;
  logic        mac_done, mac_abort, mac_coll, mac_late_coll, mac_no_carrier;

  int checks = 0;
  int errors = 0;
  int ack_cnt = 0;
  int start_at = 0;
  int starts = 0;
  int cur = 0;
  bit ack_en = 1'b1;
  bit start_seen = 1'b0;
  logic [31:0] exp_base [4];

  localparam logic [7:0] ISR_OFF = 8'h20;
  localparam logic [7:0] CFG_OFF = 8'h24;

  always #2 clk = ~clk;

  txdesc_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .slot_free(slot_free),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .tx_start(tx_start),
    .mac_done(mac_done), .mac_abort(mac_abort), .mac_coll(mac_coll),
    .mac_late_coll(mac_late_coll), .mac_no_carrier(mac_no_carrier)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: acknowledges at the negative edge, checks each byte address (R4, R3)
  always @(negedge clk) begin
    if (tx_start) begin
      start_seen = 1'b1;
      start_at   = ack_cnt;
      starts++;
    end
    if (rst_n && mem_req && ack_en) begin
      chk("R4 fetch address", mem_addr, exp_base[cur] + 32'(ack_cnt));
      ack_cnt++;
      mem_ack = 1'b1;
    end else begin
      mem_ack = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic logic [31:0] mk(int size, int thr, bit own, bit tun, bit tok,
                                     bit owc, bit tabt, bit crs);
    return {crs, tabt, owc, 7'd0, 6'(thr), tok, tun, own, 13'(size)};
  endfunction

  task automatic queue_only(int slot, int size, int thr);
    exp_base[slot] = 32'h1000_0000 + 32'(slot) * 32'h0010_0000 + 32'(size);
    wr(8'(16 + 4 * slot), exp_base[slot]);
    wr(8'(4 * slot), {10'd0, 6'(thr), 3'd0, 13'(size)});
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  // kind: 0 good, 1 underrun, 2 MAC abort, 3 collision limit, 4 good with late coll and carrier loss
  task automatic run_frame(int slot, int size, int thr, int kind, bit preq, bit keep_isr);
    logic [31:0] st, isr_v, cfg_v;
    int sp, lim;
    bit own, tok;
    sp = (thr == 0) ? size : ((thr * 32 < size) ? thr * 32 : size);
    if (!preq) queue_only(slot, size, thr);
    while (!start_seen) @(negedge clk);
    chk("R5 start point", 32'(start_at), 32'(sp));
    if (kind == 1) begin
      ack_en = 1'b0;
      @(negedge clk);
      pulse(mac_done);
    end else begin
      while (ack_cnt < size) @(negedge clk);
      @(negedge clk); @(negedge clk);
      case (kind)
        2: pulse(mac_abort);
        3: begin
          rd(CFG_OFF, cfg_v);
          lim = 16 + 16 * int'(cfg_v[7:4]);
          for (int c = 0; c < lim - 1; c++) pulse(mac_coll);
          rd(8'(4 * slot), st);
          chk("R9 no abort one short of limit", 32'(st[30]), 32'd0);
          pulse(mac_coll);
        end
        4: begin
          @(negedge clk); mac_late_coll = 1'b1; mac_no_carrier = 1'b1;
          @(negedge clk); mac_late_coll = 1'b0; mac_no_carrier = 1'b0;
          rd(8'(4 * slot), st);
          chk("R10 frame continues", 32'(st[15]), 32'd0);
          pulse(mac_done);
        end
        default: pulse(mac_done);
      endcase
    end
    chk("R4 bytes fetched", 32'(ack_cnt), (kind == 1) ? 32'(ack_cnt) : 32'(size));
    if (kind == 1) chk("R7 fetch incomplete", 32'(ack_cnt < size), 32'd1);
    cur = (cur + 1) % 4;
    ack_cnt = 0;
    start_seen = 1'b0;
    ack_en = 1'b1;
    own = (kind != 1);
    tok = (kind == 0) || (kind == 4);
    rd(8'(4 * slot), st);
    chk("R6 R7 R8 R9 R10 status word", st,
        mk(size, thr, own, kind == 1, tok, kind == 4, (kind == 2) || (kind == 3), kind == 4));
    chk("R13 slot free", 32'(slot_free[slot]), 32'(own && tok));
    rd(ISR_OFF, isr_v);
    if (tok) chk("R6 interrupt sent bit", 32'(isr_v[2]), 32'd1);
    else     chk("R7 R8 R9 interrupt error bit", 32'(isr_v[3]), 32'd1);
    if (!keep_isr) wr(ISR_OFF, 32'h0000_FFFF);
  endtask

  initial begin
    logic [31:0] v;
    int s0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    mem_ack = 1'b0; mac_done = 1'b0; mac_abort = 1'b0; mac_coll = 1'b0;
    mac_late_coll = 1'b0; mac_no_carrier = 1'b0;
    for (int i = 0; i < 4; i++) exp_base[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      rd(8'(4 * i), v);
      chk("R1 register reset", v, 32'd0);
    end
    rd(ISR_OFF, v);
    chk("R1 interrupt reset", v, 32'd0);
    chk("R1 free reset", 32'(slot_free), 32'hF);
    chk("R1 outputs idle", {30'd0, mem_req, tx_start}, 32'd0);

    // sweep: two full rotations, thresholds below, above and equal to size (R2 R3 R4 R5 R6)
    for (int f = 0; f < 8; f++) begin
      int thr;
      thr = (f % 3 == 0) ? 0 : (f + 2) % 8;
      run_frame(f % 4, 40 + 37 * f, thr, (f == 6) ? 4 : 0, 1'b0, 1'b0);
    end

    // R3: slot 1 queued out of turn must wait for slot 0; R12: busy write ignored
    s0 = starts;
    queue_only(1, 60, 0);
    repeat (20) @(negedge clk);
    chk("R3 out-of-turn slot waits", {31'd0, mem_req}, 32'd0);
    chk("R3 no start out of turn", 32'(starts), 32'(s0));
    wr(8'h04, 32'h0000_0050);
    rd(8'h04, v);
    chk("R12 busy write ignored", v, mk(60, 0, 0, 0, 0, 0, 0, 0));
    rd(ISR_OFF, v);
    chk("R12 sticky busy flag", v, 32'h0000_8000);
    wr(ISR_OFF, 32'h0000_8000);
    rd(ISR_OFF, v);
    chk("R11 busy flag cleared", v, 32'd0);
    run_frame(0, 100, 2, 2, 1'b0, 1'b0);
    run_frame(1, 60, 0, 0, 1'b1, 1'b0);

    // R2: zero size write clears flags and does not queue
    wr(8'h08, 32'h0003_0000);
    rd(8'h08, v);
    chk("R2 zero size clears flags", v, 32'h0003_0000);
    chk("R13 zero size is free", 32'(slot_free[2]), 32'd1);
    repeat (10) @(negedge clk);
    chk("R2 zero size not queued", {31'd0, mem_req}, 32'd0);

    // R7 underrun, then check fetch stopped
    run_frame(2, 200, 1, 1, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk("R7 fetch stopped", {31'd0, mem_req}, 32'd0);

    // R9 collision limit with retry field 1 (limit 32)
    wr(CFG_OFF, 32'h0000_0010);
    run_frame(3, 64, 0, 3, 1'b0, 1'b0);
    wr(CFG_OFF, 32'h0000_0000);
    run_frame(0, 33, 0, 3, 1'b0, 1'b0);

    // R11: selective write-one-to-clear
    run_frame(1, 50, 0, 0, 1'b0, 1'b1);
    run_frame(2, 70, 1, 2, 1'b0, 1'b1);
    rd(ISR_OFF, v);
    chk("R11 both bits set", v, 32'h0000_000C);
    wr(ISR_OFF, 32'h0000_0004);
    rd(ISR_OFF, v);
    chk("R11 clears only written bit", v, 32'h0000_0008);
    wr(ISR_OFF, 32'h0000_0008);
    rd(ISR_OFF, v);
    chk("R11 cleared", v, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule